// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register file of a parallel ATA drive. A host-side bus port selects either the command block or the control block, gives a 3-bit offset, a read/write strobe and write data, and gets back registered read data. The data register is 16 bits wide and every other register is 8 bits.

Every access also yields a one-cycle action code for a downstream command state machine. That machine reacts to data transfers, status polls, device selection, new commands and soft-reset edges. The block holds the status byte and the error byte, and the downstream machine can overwrite either of them. It also holds the interrupt-disable flag, the latched command opcode and the device state: idle and selected, idle and not selected, or soft reset. A strap input picks whether the device comes out of reset as device 0 or device 1. Command execution and media access belong to other blocks.

Register map. Command block (busCtl=0), by offset:
- 0: data.
- 1: error on read, features on write.
- 2: sector count.
- 3: sector number.
- 4: cylinder low.
- 5: cylinder high.
- 6: drive/head.
- 7: status on read, command on write.

Control block (busCtl=1): only offset 6 is defined. It reads as alternate status and writes as device control, where bit 2 is soft reset and bit 1 is interrupt-disable.

Action codes: 0 none, 1 data read, 2 data write, 3 status read, 4 select write, 5 command write, 6 reset set, 7 reset clear. Device state codes: 0 idle-selected, 1 idle-not-selected, 2 soft reset.

Top module: `ata_tf_top`

## Requirements
- R1: A command-block access at offset 0 moves all 16 bits. A write stores busWdata and gives action 2. A read returns the stored word and gives action 1.
- R2: A command-block read at offset 7 returns the status byte and gives action 3. A control-block read at offset 6 returns the same byte and gives action 0.
- R3: A command-block write at offset 6 gives action 4. A write at offset 7 latches busWdata[7:0] onto cmdOpcode and gives action 5.
- R4: A command-block write at offset 1 (features) gives action 0 and is discarded. A following read at offset 1 still returns the error byte.
- R5: A control write at offset 6 with bit 2 set enters soft reset (devState 2) and gives action 6, every time it is written. A later control write with bit 2 clear, made while in soft reset, gives action 7 and returns devState to the idle state of the strapped device. The same write made outside soft reset gives action 0.
- R6: Every control write at offset 6 sets nIen from bit 1 of the written byte.
- R7: After reset the error byte is 0x01, status is 0x40 (drive ready only), action is 0 and nIen is 0.
- R8: When devId is 0 during reset, devState leaves reset as 0 (idle-selected). When devId is 1, it leaves reset as 1 (idle-not-selected).
- R9: A control-block access at any offset other than 6 reads as 0x00FF and is ignored on write. It raises badAccess for one cycle and gives action 0.
- R10: The sector count, sector number, cylinder low, cylinder high and drive registers (offsets 2 to 6) each read back the low byte last written to them. The upper byte of every 8-bit read is zero.
- R11: rdData, action and badAccess are registered, so they appear in the cycle after the access. action and badAccess last exactly one cycle; in a cycle with no access, action is 0.
- R12: A pulse on stsLoad replaces the status byte with stsIn, and a pulse on errLoad replaces the error byte with errIn. Later reads show the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| devId | input | 1 | Device number strap, sampled during reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busCtl | input | 1 | 1 = control block, 0 = command block |
| busAddr | input | 3 | Register offset |
| busWdata | input | 16 | Write data (low byte for 8-bit registers) |
| stsLoad | input | 1 | Downstream load of the status byte |
| stsIn | input | 8 | New status byte |
| errLoad | input | 1 | Downstream load of the error byte |
| errIn | input | 8 | New error byte |
| rdData | output | 16 | Registered read data |
| action | output | 3 | One-cycle action code |
| badAccess | output | 1 | One-cycle undefined-offset flag |
| devState | output | 2 | Device state code |
| nIen | output | 1 | Interrupt-disable flag |
| cmdOpcode | output | 8 | Last command opcode written |

## Verification
The access strobe is captured at a rising edge, and rdData, action, badAccess, nIen, devState and cmdOpcode all take their new value at that same edge. Each result is therefore due one cycle after the access, and the action pulse has cleared one cycle after that. The bench drives each access at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge, where the pulse is still present. It then drops the strobe and waits one idle cycle before the next access, so pulses from adjacent accesses cannot merge. A downstream status or error load takes effect at its edge, and the first read after it shows the new byte one cycle later.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int TF_ADDR_W   = 3;
  localparam int TF_N_SHADOW = 5;
  localparam int TF_SHD_W    = $clog2(TF_N_SHADOW);

  // offsets whose meaning the downstream software relies on
  localparam logic [TF_ADDR_W-1:0] OFF_DATA  = 3'd0;
  localparam logic [TF_ADDR_W-1:0] OFF_ERRFT = 3'd1;
  localparam logic [TF_ADDR_W-1:0] OFF_CNT   = 3'd2;
  localparam logic [TF_ADDR_W-1:0] OFF_DRV   = 3'd6;
  localparam logic [TF_ADDR_W-1:0] OFF_STCMD = 3'd7;
  localparam logic [TF_ADDR_W-1:0] OFF_CTL   = 3'd6;

  localparam int SRST_BIT = 2;
  localparam int NIEN_BIT = 1;

  typedef enum logic [2:0] {
    ACT_NONE     = 3'd0,
    ACT_DATA_RD  = 3'd1,
    ACT_DATA_WR  = 3'd2,
    ACT_STAT_RD  = 3'd3,
    ACT_SELECT   = 3'd4,
    ACT_CMD      = 3'd5,
    ACT_SRST_SET = 3'd6,
    ACT_SRST_CLR = 3'd7
  } actCode_e;

  typedef enum logic [1:0] {
    DEV_IDLE_SEL  = 2'd0,
    DEV_IDLE_NSEL = 2'd1,
    DEV_SRST      = 2'd2
  } devState_e;

  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_DATA = 3'd1,
    SEL_ERR  = 3'd2,
    SEL_SHD  = 3'd3,
    SEL_STAT = 3'd4,
    SEL_BAD  = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic                   weData;
    logic [TF_N_SHADOW-1:0] weShadow;
    logic                   weCmd;
    logic                   weCtl;
    logic                   rdEn;
    rdSel_e                 rdSel;
    logic [TF_SHD_W-1:0]    shdIdx;
  } tfStrobe_t;
endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 devId,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic                 busCtl,
  input  logic [TF_ADDR_W-1:0] busAddr,
  input  logic                 srstReq,
  output tfStrobe_t            stb,
  output actCode_e             action,
  output logic                 badAccess,
  output devState_e            devState
);
  logic      devIdReg;
  devState_e idleState;
  devState_e nextState;
  actCode_e  actNext;
  logic      badNext;

  assign idleState = devIdReg ? DEV_IDLE_NSEL : DEV_IDLE_SEL;

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_ZERO;
    actNext   = ACT_NONE;
    badNext   = 1'b0;
    nextState = devState;
    if (busValid) begin
      if (!busCtl) begin
        if (busWrite) begin
          unique case (busAddr)
            OFF_DATA: begin
              stb.weData = 1'b1;
              actNext    = ACT_DATA_WR;
            end
            OFF_ERRFT: ;
            OFF_STCMD: begin
              stb.weCmd = 1'b1;
              actNext   = ACT_CMD;
            end
            default: begin
              stb.weShadow[TF_SHD_W'(busAddr - OFF_CNT)] = 1'b1;
              if (busAddr == OFF_DRV) actNext = ACT_SELECT;
            end
          endcase
        end else begin
          stb.rdEn = 1'b1;
          unique case (busAddr)
            OFF_DATA: begin
              stb.rdSel = SEL_DATA;
              actNext   = ACT_DATA_RD;
            end
            OFF_ERRFT: stb.rdSel = SEL_ERR;
            OFF_STCMD: begin
              stb.rdSel = SEL_STAT;
              actNext   = ACT_STAT_RD;
            end
            default: begin
              stb.rdSel  = SEL_SHD;
              stb.shdIdx = TF_SHD_W'(busAddr - OFF_CNT);
            end
          endcase
        end
      end else if (busAddr == OFF_CTL) begin
        if (busWrite) begin
          stb.weCtl = 1'b1;
          if (srstReq) begin
            nextState = DEV_SRST;
            actNext   = ACT_SRST_SET;
          end else if (devState == DEV_SRST) begin
            nextState = idleState;
            actNext   = ACT_SRST_CLR;
          end
        end else begin
          stb.rdEn  = 1'b1;
          stb.rdSel = SEL_STAT;
        end
      end else begin
        badNext = 1'b1;
        if (!busWrite) begin
          stb.rdEn  = 1'b1;
          stb.rdSel = SEL_BAD;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devIdReg  <= devId;
      devState  <= devId ? DEV_IDLE_NSEL : DEV_IDLE_SEL;
      action    <= ACT_NONE;
      badAccess <= 1'b0;
    end else begin
      devState  <= nextState;
      action    <= actNext;
      badAccess <= badNext;
    end
  end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tfStrobe_t         stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              stsLoad,
  input  logic [REG_W-1:0]  stsIn,
  input  logic              errLoad,
  input  logic [REG_W-1:0]  errIn,
  output logic [DATA_W-1:0] rdData,
  output logic              nIen,
  output logic [REG_W-1:0]  cmdOpcode
);
  localparam logic [REG_W-1:0] STS_RESET = REG_W'(8'h40);
  localparam logic [REG_W-1:0] ERR_RESET = REG_W'(8'h01);
  localparam logic [REG_W-1:0] BAD_BYTE  = '1;

  logic [DATA_W-1:0] dataReg;
  logic [REG_W-1:0]  shadow [TF_N_SHADOW];
  logic [REG_W-1:0]  statusReg;
  logic [REG_W-1:0]  errorReg;
  logic [DATA_W-1:0] rdNext;
  logic [REG_W-1:0]  shdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TF_N_SHADOW; i++) shadow[i] <= '0;
    end else begin
      for (int i = 0; i < TF_N_SHADOW; i++)
        if (stb.weShadow[i]) shadow[i] <= busWdata[REG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      cmdOpcode <= '0;
      nIen      <= 1'b0;
      statusReg <= STS_RESET;
      errorReg  <= ERR_RESET;
      rdData    <= '0;
    end else begin
      if (stb.weData) dataReg <= busWdata;
      if (stb.weCmd) cmdOpcode <= busWdata[REG_W-1:0];
      if (stb.weCtl) nIen <= busWdata[NIEN_BIT];
      if (stsLoad) statusReg <= stsIn;
      if (errLoad) errorReg <= errIn;
      if (stb.rdEn) rdData <= rdNext;
    end
  end

  always_comb begin
    shdSel = '0;
    for (int i = 0; i < TF_N_SHADOW; i++)
      if (stb.shdIdx == TF_SHD_W'(i)) shdSel = shadow[i];
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_DATA: rdNext = dataReg;
      SEL_ERR:  rdNext = DATA_W'(errorReg);
      SEL_SHD:  rdNext = DATA_W'(shdSel);
      SEL_STAT: rdNext = DATA_W'(statusReg);
      SEL_BAD:  rdNext = DATA_W'(BAD_BYTE);
      default:  rdNext = '0;
    endcase
  end
endmodule

// File: rtl/ata_tf_top.sv
module ata_tf_top
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 devId,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic                 busCtl,
  input  logic [TF_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 stsLoad,
  input  logic [REG_W-1:0]     stsIn,
  input  logic                 errLoad,
  input  logic [REG_W-1:0]     errIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [2:0]           action,
  output logic                 badAccess,
  output logic [1:0]           devState,
  output logic                 nIen,
  output logic [REG_W-1:0]     cmdOpcode
);
  tfStrobe_t stb;
  actCode_e  actCode;
  devState_e devSt;

  ata_tf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .devId     (devId),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busCtl    (busCtl),
    .busAddr   (busAddr),
    .srstReq   (busWdata[SRST_BIT]),
    .stb       (stb),
    .action    (actCode),
    .badAccess (badAccess),
    .devState  (devSt)
  );

  ata_tf_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .stsLoad   (stsLoad),
    .stsIn     (stsIn),
    .errLoad   (errLoad),
    .errIn     (errIn),
    .rdData    (rdData),
    .nIen      (nIen),
    .cmdOpcode (cmdOpcode)
  );

  assign action   = actCode;
  assign devState = devSt;
endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk
  import ata_tf_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        busCtl,
  input logic [2:0]  busAddr,
  input logic [15:0] busWdata,
  input logic [15:0] rdData,
  input logic [2:0]  action,
  input logic        badAccess,
  input logic [1:0]  devState,
  input logic        nIen,
  input logic [7:0]  cmdOpcode
);
  logic ctlWr;
  assign ctlWr = busValid && busWrite && busCtl && (busAddr == OFF_CTL);

  AST_IDLE_NO_ACT: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> action == ACT_NONE); // R11
  AST_ALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busCtl && !busWrite) |=> action == ACT_NONE); // R2
  AST_BAD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busCtl && !busWrite && busAddr != OFF_CTL) |=> (rdData == 16'h00FF) && badAccess); // R9
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> action == ACT_NONE); // R9
  AST_NIEN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> nIen == $past(busWdata[NIEN_BIT])); // R6
  AST_SRST_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && busWdata[SRST_BIT]) |=> (action == ACT_SRST_SET) && (devState == DEV_SRST)); // R5
  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !busCtl && busAddr == OFF_STCMD) |=> (cmdOpcode == $past(busWdata[7:0])) && (action == ACT_CMD)); // R3
endmodule

bind ata_tf_top ata_tf_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busCtl    (busCtl),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .rdData    (rdData),
  .action    (action),
  .badAccess (badAccess),
  .devState  (devState),
  .nIen      (nIen),
  .cmdOpcode (cmdOpcode)
);

// File: tb/tb_ata_tf_top.sv
`timescale 1ns/1ps
module tb_ata_tf_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devId = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, busCtl = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        stsLoad = 1'b0, errLoad = 1'b0;
  logic [7:0]  stsIn = '0, errIn = '0;
  logic [15:0] rdData;
  logic [2:0]  action;
  logic        badAccess;
  logic [1:0]  devState;
  logic        nIen;
  logic [7:0]  cmdOpcode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ata_tf_top dut (
    .clk(clk), .rstN(rstN), .devId(devId), .busValid(busValid),
    .busWrite(busWrite), .busCtl(busCtl), .busAddr(busAddr),
    .busWdata(busWdata), .stsLoad(stsLoad), .stsIn(stsIn),
    .errLoad(errLoad), .errIn(errIn), .rdData(rdData), .action(action),
    .badAccess(badAccess), .devState(devState), .nIen(nIen),
    .cmdOpcode(cmdOpcode)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access for a single cycle; outputs are sampled on return
  task automatic acc(input logic w, input logic c, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = w; busCtl = c; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic doReset(input logic id);
    @(negedge clk);
    rstN = 1'b0; devId = id;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // {write, ctl, addr, wdata, expAction, checkRd, expRd, expBad}
  localparam int NV = 22;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd2, 16'hA512, 3'd0, 1'b0, 16'h0000, 1'b0}, // R10 count
    {1'b0, 1'b0, 3'd2, 16'h0000, 3'd0, 1'b1, 16'h0012, 1'b0},
    {1'b1, 1'b0, 3'd3, 16'h0034, 3'd0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 1'b0, 3'd3, 16'h0000, 3'd0, 1'b1, 16'h0034, 1'b0},
    {1'b1, 1'b0, 3'd4, 16'h0056, 3'd0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 1'b0, 3'd4, 16'h0000, 3'd0, 1'b1, 16'h0056, 1'b0},
    {1'b1, 1'b0, 3'd5, 16'hAB78, 3'd0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 1'b0, 3'd5, 16'h0000, 3'd0, 1'b1, 16'h0078, 1'b0},
    {1'b1, 1'b0, 3'd6, 16'h00E0, 3'd4, 1'b0, 16'h0000, 1'b0}, // R3 select
    {1'b0, 1'b0, 3'd6, 16'h0000, 3'd0, 1'b1, 16'h00E0, 1'b0},
    {1'b0, 1'b0, 3'd2, 16'h0000, 3'd0, 1'b1, 16'h0012, 1'b0},
    {1'b1, 1'b0, 3'd0, 16'hBEEF, 3'd2, 1'b0, 16'h0000, 1'b0}, // R1
    {1'b0, 1'b0, 3'd0, 16'h0000, 3'd1, 1'b1, 16'hBEEF, 1'b0},
    {1'b0, 1'b0, 3'd7, 16'h0000, 3'd3, 1'b1, 16'h0040, 1'b0}, // R2
    {1'b0, 1'b1, 3'd6, 16'h0000, 3'd0, 1'b1, 16'h0040, 1'b0},
    {1'b1, 1'b0, 3'd1, 16'h00AA, 3'd0, 1'b0, 16'h0000, 1'b0}, // R4
    {1'b0, 1'b0, 3'd1, 16'h0000, 3'd0, 1'b1, 16'h0001, 1'b0},
    {1'b1, 1'b1, 3'd3, 16'h0006, 3'd0, 1'b0, 16'h0000, 1'b1}, // R9
    {1'b0, 1'b1, 3'd2, 16'h0000, 3'd0, 1'b1, 16'h00FF, 1'b1},
    {1'b0, 1'b1, 3'd7, 16'h0000, 3'd0, 1'b1, 16'h00FF, 1'b1},
    {1'b1, 1'b0, 3'd7, 16'h00C8, 3'd5, 1'b0, 16'h0000, 1'b0}, // R3 cmd
    {1'b0, 1'b0, 3'd0, 16'h0000, 3'd1, 1'b1, 16'hBEEF, 1'b0}
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    // R7 R8 reset state
    chk("R7 action after reset", 16'(action), 16'd0);
    chk("R7 nIen after reset", 16'(nIen), 16'd0);
    chk("R8 devState dev0", 16'(devState), 16'd0);
    acc(1'b0, 1'b0, 3'd1, 16'h0);
    chk("R7 error reset", rdData, 16'h0001);
    acc(1'b0, 1'b0, 3'd7, 16'h0);
    chk("R7 status reset", rdData, 16'h0040);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      acc(v[41], v[40], v[39:37], v[36:21]);
      chk($sformatf("R11 vec%0d action", i), 16'(action), 16'(v[20:18]));
      chk($sformatf("R9 vec%0d badAccess", i), 16'(badAccess), 16'(v[0]));
      if (v[17]) chk($sformatf("R10 vec%0d rdData", i), rdData, v[16:1]);
    end
    chk("R3 cmdOpcode", 16'(cmdOpcode), 16'h00C8);
    @(negedge clk);
    chk("R11 pulse cleared", 16'(action), 16'd0);
    chk("R11 bad cleared", 16'(badAccess), 16'd0);

    // R5 R6 soft reset sequence, device 0
    acc(1'b1, 1'b1, 3'd6, 16'h0002);
    chk("R6 nIen set", 16'(nIen), 16'd1);
    chk("R5 clear outside srst", 16'(action), 16'd0);
    acc(1'b1, 1'b1, 3'd6, 16'h0004);
    chk("R5 set action", 16'(action), 16'd6);
    chk("R5 srst state", 16'(devState), 16'd2);
    chk("R6 nIen cleared", 16'(nIen), 16'd0);
    acc(1'b1, 1'b1, 3'd6, 16'h0006);
    chk("R5 set again", 16'(action), 16'd6);
    chk("R6 nIen set in srst", 16'(nIen), 16'd1);
    acc(1'b1, 1'b1, 3'd6, 16'h0000);
    chk("R5 clear action", 16'(action), 16'd7);
    chk("R5 back to idle dev0", 16'(devState), 16'd0);
    acc(1'b1, 1'b1, 3'd6, 16'h0000);
    chk("R5 second clear quiet", 16'(action), 16'd0);

    // R12 downstream loads
    @(negedge clk);
    stsLoad = 1'b1; stsIn = 8'h58; errLoad = 1'b1; errIn = 8'h04;
    @(negedge clk);
    stsLoad = 1'b0; errLoad = 1'b0;
    acc(1'b0, 1'b0, 3'd7, 16'h0);
    chk("R12 status loaded", rdData, 16'h0058);
    chk("R2 status read action", 16'(action), 16'd3);
    acc(1'b0, 1'b1, 3'd6, 16'h0);
    chk("R2 alt status", rdData, 16'h0058);
    chk("R2 alt no action", 16'(action), 16'd0);
    acc(1'b0, 1'b0, 3'd1, 16'h0);
    chk("R12 error loaded", rdData, 16'h0004);

    // R8 device 1
    doReset(1'b1);
    chk("R8 devState dev1", 16'(devState), 16'd1);
    acc(1'b1, 1'b1, 3'd6, 16'h0004);
    chk("R5 dev1 srst", 16'(devState), 16'd2);
    acc(1'b1, 1'b1, 3'd6, 16'h0000);
    chk("R5 dev1 clear action", 16'(action), 16'd7);
    chk("R8 dev1 back to nsel", 16'(devState), 16'd1);
    acc(1'b0, 1'b0, 3'd2, 16'h0);
    chk("R7 shadow cleared by reset", rdData, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule